// File: doc/BRIEF.md
# Serial PHY Management Master (Clause 22)

This block lets a processor reach the management registers of external PHYs over the two-wire management bus. Software writes one 32-bit command word that holds the target PHY address, the target register address, the direction and, for a write, the 16-bit payload. That single write both records the command and launches a Clause 22 frame. The controller then drives the management clock, shifts the frame out most significant bit first, and hands the data line to the PHY for the turnaround and data phase of a read. While the frame is in flight a busy bit in the same word reads 1. When a read ends with a valid turnaround, the captured 16-bit value appears in the low half of the word together with a read-valid bit.

Completion is also signalled through an interrupt path. A done cause bit sets at the end of every frame. Software clears it by writing 0 to that bit; writing 1 leaves it as it is. A mask register gates the cause onto the interrupt pin. The management clock runs at the core clock divided by 2*MDC_HALF. At the default setting of 20, one 64-bit frame takes 2,560 core cycles, which is 25.6 us at 100 MHz and well within a 1 ms software timeout.

Registers sit on a simple single-cycle bus. Writes are taken on csr_we. Reads are combinational from csr_addr. The command word is at 0x00, the cause register at 0x7C and the mask register at 0x80. There is no stream data path, so no port uses a valid/ready handshake.

Top module: `phy_mgmt_master`

## Requirements
- R1: A write to offset 0x00 while idle launches a frame. The command word places the write data in bits 15:0, the PHY address in bits 20:16, the register address in bits 25:21 and the direction in bit 26 (1 = read, 0 = write). With bit 26 at 0 the master drives all 64 bits, MSB first: 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10, then the 16 data bits.
- R2: A read frame carries opcode 10. The master drives bits 0 to 45 of the frame and releases the line (mdio_oe = 0) for the turnaround and all 16 data bits (frame bits 46 to 63).
- R3: Bit 28 of the command word reads 1 from the cycle after an accepted command until the frame completes, and 0 otherwise.
- R4: If the PHY drives frame bit 47 (the second turnaround bit) to 0 on a read, then at completion bit 27 (read-valid) is 1 and bits 15:0 hold the 16 bits sampled on the rising MDC edges of frame bits 48 to 63, first bit as MSB.
- R5: If the line is not 0 during frame bit 47 of a read, read-valid stays 0 after completion.
- R6: A write to offset 0x00 while busy is ignored. The frame on the wire and the fields read back in bits 26:0 are those of the command in flight.
- R7: Read-valid is cleared in the cycle after a new command is accepted.
- R8: Bit 4 of the cause register (0x7C) sets when a frame completes. Writing 0 to bit 4 clears it. Writing 1 to bit 4 keeps it set.
- R9: irq equals cause bit 4 AND mask bit 4 (0x80). Writing 0 to the mask register forces irq low.
- R10: MDC idles low. While a frame runs, MDC has a period of 2*MDC_HALF core cycles, and a frame has exactly 64 rising MDC edges.
- R11: After reset all three registers read 0, irq is 0, MDC is 0 and mdio_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 8 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for csr_addr |
| irq | output | 1 | Masked completion interrupt |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data sampled from the line |

## Verification
The hardest cases to reach from the ports are the read corner cases. They need a PHY that keeps step with the frame: it must release the line during the turnaround, drive (or fail to drive) the second turnaround bit, and then shift data out bit by bit. The bench models the PHY with a counter that advances on each falling MDC edge and indexes a 64-bit response vector. This lets one test pull bit 47 low and another leave it high. A second awkward case is a command written mid-frame. The bench starts a write, issues a conflicting command a few cycles later, and then compares the whole captured frame and the readback against the first command.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int FRAME_LEN = 64;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int DATA_W    = 16;
  localparam int AD_W      = 5;
  localparam int TA_FIRST  = 46;
  localparam int TA_LAST   = 47;
  localparam int DATA_POS  = 48;

  localparam int PHY_LSB    = 16;
  localparam int REG_LSB    = 21;
  localparam int OP_BIT     = 26;
  localparam int RVALID_BIT = 27;
  localparam int BUSY_BIT   = 28;
  localparam int DONE_BIT   = 4;

  localparam logic [7:0] OFF_CMD   = 8'h00;
  localparam logic [7:0] OFF_CAUSE = 8'h7C;
  localparam logic [7:0] OFF_MASK  = 8'h80;

  typedef struct packed {
    logic              rd;
    logic [AD_W-1:0]   regad;
    logic [AD_W-1:0]   phy;
    logic [DATA_W-1:0] wdata;
  } mgmt_cmd_t;

  function automatic logic [FRAME_LEN-1:0] build_frame(input mgmt_cmd_t c);
    build_frame = {32'hFFFF_FFFF, 2'b01, (c.rd ? 2'b10 : 2'b01), c.phy, c.regad,
                   (c.rd ? 2'b11 : 2'b10), (c.rd ? 16'hFFFF : c.wdata)};
  endfunction
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int MDC_HALF = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CNT_W = $clog2(MDC_HALF + 1);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(MDC_HALF - 1);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap     = en && (cnt == TERM);
  assign rise_stb = wrap && !mdc;
  assign fall_stb = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R10
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !mdc);
endmodule

// File: rtl/mgmt_shifter.sv
module mgmt_shifter
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mgmt_cmd_t         cmd,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              active,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              rd_ok,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA1_IDX  = IDX_W'(TA_FIRST);
  localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(TA_LAST);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_POS);

  logic [FRAME_LEN-1:0] sreg;
  logic [IDX_W-1:0]     idx;
  logic                 rd_q;
  logic                 ta_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg    <= '0;
      idx     <= '0;
      rd_q    <= 1'b0;
      ta_ok   <= 1'b0;
      active  <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sreg   <= build_frame(cmd);
        idx    <= '0;
        rd_q   <= cmd.rd;
        ta_ok  <= 1'b0;
        active <= 1'b1;
      end else if (active) begin
        if (rise_stb && rd_q) begin
          if (idx == TA2_IDX) ta_ok <= !mdio_i;
          if (idx >= DAT_IDX) rd_data <= {rd_data[DATA_W-2:0], mdio_i};
        end
        if (fall_stb) begin
          if (idx == LAST_IDX) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            idx  <= idx + 1'b1;
            sreg <= {sreg[FRAME_LEN-2:0], 1'b1};
          end
        end
      end
    end
  end

  assign mdio_o  = active ? sreg[FRAME_LEN-1] : 1'b1;
  assign mdio_oe = active && !(rd_q && (idx >= TA1_IDX));
  assign rd_ok   = rd_q && ta_ok;

  // R2
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> $past(start));
  // R10
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fall_stb));
endmodule

// File: rtl/phy_mgmt_master.sv
module phy_mgmt_master
  import phy_mgmt_pkg::*;
#(
  parameter int MDC_HALF = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [7:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        irq,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              busy_q, rvalid_q, cause_q, mask_q, op_q;
  logic [AD_W-1:0]   phy_q, reg_q;
  logic [DATA_W-1:0] data_q;
  logic              cmd_wr, cmd_accept, cause_wr, mask_wr;
  logic              sh_active, sh_done, sh_ok, rise_stb, fall_stb;
  logic [DATA_W-1:0] sh_data;
  mgmt_cmd_t         new_cmd;
  logic              unused_wbits;

  assign cmd_wr     = csr_we && (csr_addr == OFF_CMD);
  assign cause_wr   = csr_we && (csr_addr == OFF_CAUSE);
  assign mask_wr    = csr_we && (csr_addr == OFF_MASK);
  assign cmd_accept = cmd_wr && !busy_q;

  assign new_cmd.rd    = csr_wdata[OP_BIT];
  assign new_cmd.regad = csr_wdata[REG_LSB +: AD_W];
  assign new_cmd.phy   = csr_wdata[PHY_LSB +: AD_W];
  assign new_cmd.wdata = csr_wdata[DATA_W-1:0];
  assign unused_wbits  = ^csr_wdata[31:27];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      rvalid_q <= 1'b0;
      op_q     <= 1'b0;
      phy_q    <= '0;
      reg_q    <= '0;
      data_q   <= '0;
      cause_q  <= 1'b0;
      mask_q   <= 1'b0;
    end else begin
      if (cmd_accept) begin
        busy_q   <= 1'b1;
        rvalid_q <= 1'b0;
        op_q     <= new_cmd.rd;
        phy_q    <= new_cmd.phy;
        reg_q    <= new_cmd.regad;
        data_q   <= new_cmd.wdata;
      end else if (sh_done) begin
        busy_q   <= 1'b0;
        rvalid_q <= sh_ok;
        if (sh_ok) data_q <= sh_data;
      end
      if (sh_done) cause_q <= 1'b1;
      else if (cause_wr && !csr_wdata[DONE_BIT]) cause_q <= 1'b0;
      if (mask_wr) mask_q <= csr_wdata[DONE_BIT];
    end
  end

  assign irq = cause_q && mask_q;

  always_comb begin
    csr_rdata = '0;
    unique case (csr_addr)
      OFF_CMD: begin
        csr_rdata[BUSY_BIT]           = busy_q;
        csr_rdata[RVALID_BIT]         = rvalid_q;
        csr_rdata[OP_BIT]             = op_q;
        csr_rdata[REG_LSB +: AD_W]    = reg_q;
        csr_rdata[PHY_LSB +: AD_W]    = phy_q;
        csr_rdata[DATA_W-1:0]         = data_q;
      end
      OFF_CAUSE: csr_rdata[DONE_BIT] = cause_q;
      OFF_MASK:  csr_rdata[DONE_BIT] = mask_q;
      default:   csr_rdata = '0;
    endcase
  end

  mgmt_mdc_gen #(.MDC_HALF(MDC_HALF)) u_mdc (
    .clk(clk), .rst_n(rst_n), .en(sh_active),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mgmt_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(cmd_accept), .cmd(new_cmd),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .active(sh_active), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(sh_done), .rd_ok(sh_ok), .rd_data(sh_data)
  );

  // R3
  busy_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !sh_active) |-> (sh_done || $past(cmd_accept)));
  // R6
  hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_wr) |=> ($stable(phy_q) && $stable(reg_q) && $stable(op_q)));
  // R7
  rvalid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> !rvalid_q);
  // R8
  cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_done |=> cause_q);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q |-> !irq);
endmodule

// File: tb/phy_mgmt_master_test.sv
module phy_mgmt_master_test;
  localparam int CLK_P = 10;
  localparam int HALF  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [7:0]  csr_addr = 8'h00;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        irq, mdc, mdio_o, mdio_oe, mdio_i;

  int total = 0;
  int bad = 0;

  logic [63:0] cap_bits, cap_oe, resp;
  int          nrise, phy_idx;
  logic        resp_on = 1'b0;
  time         last_rise, period;

  always #(CLK_P/2) clk = ~clk;

  phy_mgmt_master #(.MDC_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign mdio_i = (resp_on && !mdio_oe && phy_idx < 64) ? resp[63 - phy_idx] : 1'b1;

  always @(posedge mdc) begin
    cap_bits  = {cap_bits[62:0], mdio_oe ? mdio_o : 1'b0};
    cap_oe    = {cap_oe[62:0], mdio_oe};
    period    = $time - last_rise;
    last_rise = $time;
    nrise     = nrise + 1;
  end
  always @(negedge mdc) phy_idx = phy_idx + 1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic [7:0] a, output logic [31:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  function automatic logic [31:0] cmd_word(input logic rd, input logic [4:0] ph,
                                           input logic [4:0] rg, input logic [15:0] dt);
    return {5'b0, rd, rg, ph, dt};
  endfunction

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] ph,
                                            input logic [4:0] rg, input logic [15:0] dt);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), ph, rg, 2'b10, dt};
  endfunction

  task automatic arm_capture();
    cap_bits = '0; cap_oe = '0; nrise = 0; phy_idx = 0; period = 0; last_rise = $time;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      csr_read(8'h00, v);
      if (!v[28]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    csr_read(8'h00, v); check("R11 cmd", v, 0);
    csr_read(8'h7C, v); check("R11 cause", v, 0);
    csr_read(8'h80, v); check("R11 mask", v, 0);
    check("R11 irq/mdc/oe", {irq, mdc, mdio_oe}, 0);
  endtask

  task automatic t_write(input logic [4:0] ph, input logic [4:0] rg, input logic [15:0] dt);
    logic [31:0] v;
    arm_capture();
    csr_write(8'h00, cmd_word(1'b0, ph, rg, dt));
    csr_read(8'h00, v);
    check("R3 busy set", v[28], 1);
    wait_idle();
    csr_read(8'h00, v);
    check("R3 busy clear", v[28], 0);
    check("R1 write frame", cap_bits, exp_frame(1'b0, ph, rg, dt));
    check("R1 driven all bits", cap_oe, '1);
    check("R10 rise count", nrise, 64);
    check("R10 mdc period", period, 2 * HALF * CLK_P);
    check("R10 idle low", mdc, 0);
  endtask

  task automatic t_read(input logic [4:0] ph, input logic [4:0] rg, input logic [15:0] dt,
                        input logic ta_good);
    logic [31:0] v;
    resp = {{46{1'b1}}, 1'b1, (ta_good ? 1'b0 : 1'b1), dt};
    resp_on = 1'b1;
    arm_capture();
    csr_write(8'h00, cmd_word(1'b1, ph, rg, 16'h0000));
    wait_idle();
    resp_on = 1'b0;
    check("R2 read header", cap_bits[63:18], exp_frame(1'b1, ph, rg, 16'h0) >> 18);
    check("R2 line released", cap_oe[17:0], 0);
    csr_read(8'h00, v);
    if (ta_good) begin
      check("R4 read valid", v[27], 1);
      check("R4 read data", v[15:0], dt);
    end else begin
      check("R5 no valid", v[27], 0);
    end
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    arm_capture();
    csr_write(8'h00, cmd_word(1'b0, 5'h03, 5'h11, 16'h1234));
    repeat (5) @(negedge clk);
    csr_write(8'h00, cmd_word(1'b1, 5'h1C, 5'h02, 16'hBEEF));
    csr_read(8'h00, v);
    check("R6 fields kept", v[26:0], cmd_word(1'b0, 5'h03, 5'h11, 16'h1234));
    wait_idle();
    check("R6 frame kept", cap_bits, exp_frame(1'b0, 5'h03, 5'h11, 16'h1234));
  endtask

  task automatic t_rvalid_clear();
    logic [31:0] v;
    t_read(5'h05, 5'h06, 16'h5A5A, 1'b1);
    csr_write(8'h00, cmd_word(1'b0, 5'h00, 5'h00, 16'h0000));
    csr_read(8'h00, v);
    check("R7 valid cleared", v[27], 0);
    wait_idle();
  endtask

  task automatic t_irq();
    logic [31:0] v;
    csr_write(8'h7C, 32'h0);
    csr_read(8'h7C, v); check("R8 cleared", v, 0);
    csr_write(8'h80, 32'h10);
    check("R9 irq idle", irq, 0);
    t_write(5'h01, 5'h02, 16'h00FF);
    csr_read(8'h7C, v); check("R8 done set", v, 32'h10);
    check("R9 irq high", irq, 1);
    csr_write(8'h7C, 32'hFFFF_FFFF);
    csr_read(8'h7C, v); check("R8 write one keeps", v, 32'h10);
    csr_write(8'h80, 32'h0);
    check("R9 masked", irq, 0);
    csr_write(8'h7C, 32'hFFFF_FFEF);
    csr_read(8'h7C, v); check("R8 write zero clears", v, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    resp = '1;
    arm_capture();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write(5'h1F, 5'h00, 16'hA5C3);
    t_write(5'h00, 5'h1F, 16'h0001);
    t_read(5'h0A, 5'h15, 16'hC0DE, 1'b1);
    t_read(5'h12, 5'h04, 16'h8001, 1'b0);
    t_busy_ignore();
    t_rvalid_clear();
    t_irq();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule